// File: doc/BRIEF.md
# I2C Master Bus Condition Sequencer

This block turns single-cycle software commands into the bus events an I2C master needs: Start, Repeated Start, Stop, the reception of one byte, the sending of an acknowledge bit after a reception, and the check of the slave's acknowledge after a transmitted byte. Each command is a write-one input. An accepted command sets its bit in a status vector, and the hardware clears that bit when the bus phase finishes. The clearing comes with a one-cycle done pulse, which can serve as the interrupt.

The block drives both bus lines in open-drain form. An output of 1 pulls the line low and 0 releases it. Bus timing comes from an external divider tick. Each tick moves the active phase on by one quarter of a bit time. A phase takes four ticks and a byte reception takes thirty-two. The transmit shifter is outside the block. After the transmitter has sent eight bits, software issues the acknowledge-check command, and the sampled level is left in a status bit.

Top module: `i2c_cond_seq`

## Requirements
- R1: After reset both line drives are released (`sda_oe` = 0, `scl_oe` = 0), `active_cmd` = 0, `done` = 0, `ack_stat` = 0 and `rx_data` = 0.
- R2: Start (`cmd_start`, `active_cmd` bit 0): SDA falls while SCL is high, and the phase ends with both lines pulled low.
- R3: Repeated Start (`cmd_rstart`, bit 1): SDA is released while SCL is low, SCL is then released, and SDA falls while SCL is high. The phase ends with both lines pulled low.
- R4: Stop (`cmd_stop`, bit 2): SDA rises while SCL is high, and the phase ends with both lines released.
- R5: Receive (`cmd_rcv`, bit 3): the block gives eight SCL pulses with SDA released and samples SDA once in each high period, most significant bit first. `rx_data` takes the byte in the cycle that `done` rises.
- R6: Acknowledge sequence (`cmd_ack`, bit 4): one SCL pulse during which SDA carries the level of `ack_data` latched at acceptance. 0 pulls SDA low (ACK) and 1 releases it (NACK).
- R7: Acknowledge check (`cmd_ackchk`, bit 5): one SCL pulse with SDA released. `ack_stat` takes the sampled level: 1 means no acknowledge and 0 means acknowledged.
- R8: An accepted command sets only its own bit of `active_cmd`. The bit stays set until the phase completes and reads 0 in the cycle `done` is high.
- R9: `done` is high for exactly one cycle per completed phase.
- R10: A command that arrives while a phase is active is ignored. `active_cmd` and the bus waveform are unchanged.
- R11: If several commands arrive together while idle, only the lowest-numbered `active_cmd` bit is accepted (Start first, acknowledge check last).
- R12: Each phase advances one quarter step per `tick`. A single-bit phase completes on its 4th tick after acceptance and a reception on its 32nd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Quarter-bit timing strobe |
| cmd_start | input | 1 | Write-one Start command |
| cmd_rstart | input | 1 | Write-one Repeated Start command |
| cmd_stop | input | 1 | Write-one Stop command |
| cmd_rcv | input | 1 | Write-one receive-byte command |
| cmd_ack | input | 1 | Write-one acknowledge-sequence command |
| cmd_ackchk | input | 1 | Write-one acknowledge-check command |
| ack_data | input | 1 | Bit to send in the acknowledge sequence (1 = NACK) |
| sda_in | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_oe | output | 1 | 1 pulls SCL low |
| rx_data | output | 8 | Last received byte |
| ack_stat | output | 1 | Slave acknowledge status (1 = not acknowledged) |
| active_cmd | output | 6 | Command in progress, hardware-cleared |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `sda_in` follows the bus, so it reads low whenever `sda_oe` is set. They also assume that the slave changes SDA only while SCL is pulled low, and that commands are sequenced so each waveform starts from the line levels the previous phase left. The bench builds the bus as a wired-AND of the master drive and a slave model. The slave model shifts its next bit only on a falling SCL edge. Commands come in a legal order: Start first, then reception, acknowledge and check phases, then Repeated Start and Stop. The one deliberate exception is a command injected while a phase is active.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int NCMD = 6;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_START  = 3'd1,
    PH_RSTART = 3'd2,
    PH_STOP   = 3'd3,
    PH_RCV    = 3'd4,
    PH_ACK    = 3'd5,
    PH_ACKCHK = 3'd6
  } phase_e;
endpackage

// File: rtl/i2c_seq_timer.sv
module i2c_seq_timer #(
  parameter int BITS = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       run,
  input  logic       tick,
  input  logic       multi,
  output logic [1:0] q_nxt,
  output logic       samp,
  output logic       last
);
  localparam int BW = (BITS > 1) ? $clog2(BITS) : 1;
  localparam logic [BW-1:0] LASTBIT = BW'(BITS - 1);

  logic [1:0]    q_r;
  logic [BW-1:0] b_r, b_d;
  logic          adv;

  assign adv = run & tick;

  always_comb begin
    q_nxt = q_r;
    b_d   = b_r;
    if (load) begin
      q_nxt = 2'd0;
      b_d   = '0;
    end else if (adv) begin
      q_nxt = q_r + 2'd1;
      if (q_r == 2'd3) b_d = b_r + 1'b1;
    end
  end

  assign samp = adv & (q_r == 2'd1);
  assign last = adv & (q_r == 2'd3) & (~multi | (b_r == LASTBIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= 2'd0;
      b_r <= '0;
    end else if (load | adv) begin
      q_r <= q_nxt;
      b_r <= b_d;
    end
  end
endmodule

// File: rtl/i2c_seq_wave.sv
module i2c_seq_wave
  import i2c_seq_pkg::*;
(
  input  phase_e     phase,
  input  logic [1:0] q,
  input  logic       ack_lvl,
  output logic       sda_low,
  output logic       scl_low
);
  always_comb begin
    sda_low = 1'b0;
    scl_low = 1'b0;
    unique case (phase)
      PH_START: begin
        sda_low = (q != 2'd0);
        scl_low = (q == 2'd3);
      end
      PH_RSTART: begin
        sda_low = q[1];
        scl_low = (q == 2'd0) | (q == 2'd3);
      end
      PH_STOP: begin
        sda_low = ~q[1];
        scl_low = (q == 2'd0);
      end
      PH_ACK: begin
        sda_low = ~ack_lvl;
        scl_low = (q == 2'd0) | (q == 2'd3);
      end
      PH_RCV, PH_ACKCHK: begin
        sda_low = 1'b0;
        scl_low = (q == 2'd0) | (q == 2'd3);
      end
      default: begin
        sda_low = 1'b0;
        scl_low = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/i2c_seq_rxshift.sv
module i2c_seq_rxshift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              commit,
  input  logic              sda_in,
  output logic [DATA_W-1:0] rx_data
);
  logic [DATA_W-1:0] sh_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_r    <= '0;
      rx_data <= '0;
    end else begin
      if (shift_en) sh_r <= {sh_r[DATA_W-2:0], sda_in};
      if (commit)   rx_data <= sh_r;
    end
  end

  AST_COMMIT_AFTER_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |-> !commit) else $error("shift and commit in same cycle"); // R5
endmodule

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq
  import i2c_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cmd_start,
  input  logic              cmd_rstart,
  input  logic              cmd_stop,
  input  logic              cmd_rcv,
  input  logic              cmd_ack,
  input  logic              cmd_ackchk,
  input  logic              ack_data,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic              scl_oe,
  output logic [DATA_W-1:0] rx_data,
  output logic              ack_stat,
  output logic [NCMD-1:0]   active_cmd,
  output logic              done
);
  logic [1:0] rst_sync;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  phase_e          phase_q, phase_d, pick_ph;
  logic [NCMD-1:0] cmd_vec, pick_oh, active_d;
  logic            accept, running, samp, last;
  logic [1:0]      q_nxt;
  logic            ack_lat, ack_lat_d;
  logic            sda_low_d, scl_low_d, sda_oe_d, scl_oe_d;

  assign cmd_vec = {cmd_ackchk, cmd_ack, cmd_rcv, cmd_stop, cmd_rstart, cmd_start};
  assign running = (phase_q != PH_IDLE);
  assign accept  = ~running & (|cmd_vec);

  always_comb begin
    pick_oh = '0;
    pick_ph = PH_IDLE;
    for (int i = NCMD - 1; i >= 0; i--) begin
      if (cmd_vec[i]) begin
        pick_oh = '0;
        pick_oh[i] = 1'b1;
        pick_ph = phase_e'(i + 1);
      end
    end
  end

  always_comb begin
    phase_d   = phase_q;
    active_d  = active_cmd;
    ack_lat_d = ack_lat;
    if (accept) begin
      phase_d   = pick_ph;
      active_d  = pick_oh;
      ack_lat_d = ack_data;
    end else if (last) begin
      phase_d  = PH_IDLE;
      active_d = '0;
    end
  end

  i2c_seq_timer #(.BITS(DATA_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_i_n),
    .load  (accept),
    .run   (running),
    .tick  (tick),
    .multi (phase_q == PH_RCV),
    .q_nxt (q_nxt),
    .samp  (samp),
    .last  (last)
  );

  i2c_seq_wave u_wave (
    .phase   (phase_d),
    .q       (q_nxt),
    .ack_lvl (ack_lat_d),
    .sda_low (sda_low_d),
    .scl_low (scl_low_d)
  );

  assign sda_oe_d = (phase_d != PH_IDLE) ? sda_low_d : sda_oe;
  assign scl_oe_d = (phase_d != PH_IDLE) ? scl_low_d : scl_oe;

  i2c_seq_rxshift #(.DATA_W(DATA_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .shift_en (samp & (phase_q == PH_RCV)),
    .commit   (last & (phase_q == PH_RCV)),
    .sda_in   (sda_in),
    .rx_data  (rx_data)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      phase_q    <= PH_IDLE;
      active_cmd <= '0;
      ack_lat    <= 1'b0;
      ack_stat   <= 1'b0;
      done       <= 1'b0;
      sda_oe     <= 1'b0;
      scl_oe     <= 1'b0;
    end else begin
      phase_q    <= phase_d;
      active_cmd <= active_d;
      ack_lat    <= ack_lat_d;
      done       <= last;
      sda_oe     <= sda_oe_d;
      scl_oe     <= scl_oe_d;
      if (samp && phase_q == PH_ACKCHK) ack_stat <= sda_in;
    end
  end

  AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0(active_cmd)) else $error("several commands active"); // R8
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |-> (active_cmd == '0)) else $error("command bit not cleared"); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_i_n)
    done |=> !done) else $error("done longer than one cycle"); // R9
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_i_n)
    (running && !last) |=> $stable(active_cmd)) else $error("command taken while busy"); // R10
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_i_n)
    (last && phase_q == PH_STOP) |=> (!sda_oe && !scl_oe)) else $error("stop left a line low"); // R4
  AST_RX_SDA_FREE: assert property (@(posedge clk) disable iff (!rst_i_n)
    (phase_q == PH_RCV || phase_q == PH_ACKCHK) |-> !sda_oe) else $error("SDA driven while listening"); // R7
  AST_START_ENDS_LOW: assert property (@(posedge clk) disable iff (!rst_i_n)
    (last && phase_q == PH_START) |=> (sda_oe && scl_oe)) else $error("start did not end low"); // R2
endmodule

// File: tb/i2c_cond_seq_test.sv
module i2c_cond_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic c_start = 1'b0, c_rstart = 1'b0, c_stop = 1'b0;
  logic c_rcv = 1'b0, c_ack = 1'b0, c_ackchk = 1'b0;
  logic ack_data = 1'b0;
  logic sda_oe, scl_oe, ack_stat, done;
  logic [7:0] rx_data;
  logic [5:0] active_cmd;

  logic [7:0] slave_byte = 8'hFF;
  logic       slave_en = 1'b0;
  int         slave_idx = 0;
  logic       slave_sda, sda_line, scl_line;

  int checks = 0, fails = 0;
  int tick_cnt = 0;
  int tcnt = 0;
  logic prev_sda = 1'b1, prev_scl = 1'b1;
  logic start_ev = 1'b0, stop_ev = 1'b0, hi_sda = 1'b1, hi_sda_first = 1'b1;
  logic seen_rise = 1'b0;

  always #5 clk = ~clk;

  assign slave_sda = slave_en ? slave_byte[7 - slave_idx] : 1'b1;
  assign sda_line  = ~sda_oe & slave_sda;
  assign scl_line  = ~scl_oe;

  i2c_cond_seq uut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .cmd_start(c_start), .cmd_rstart(c_rstart), .cmd_stop(c_stop),
    .cmd_rcv(c_rcv), .cmd_ack(c_ack), .cmd_ackchk(c_ackchk),
    .ack_data(ack_data), .sda_in(sda_line),
    .sda_oe(sda_oe), .scl_oe(scl_oe), .rx_data(rx_data),
    .ack_stat(ack_stat), .active_cmd(active_cmd), .done(done)
  );

  always @(negedge clk) begin
    logic t;
    t = (tcnt == 3);
    tcnt = (tcnt + 1) % 4;
    if (t && active_cmd != 6'd0) tick_cnt++;
    tick <= t;
    if (prev_scl && scl_line && prev_sda && !sda_line) start_ev = 1'b1;
    if (prev_scl && scl_line && !prev_sda && sda_line) stop_ev = 1'b1;
    if (!prev_scl && scl_line) begin
      hi_sda = sda_line;
      if (!seen_rise) hi_sda_first = sda_line;
      seen_rise = 1'b1;
    end
    if (slave_en && prev_scl && !scl_line && slave_idx < 7) slave_idx++;
    prev_sda = sda_line;
    prev_scl = scl_line;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_ev();
    start_ev = 1'b0; stop_ev = 1'b0; seen_rise = 1'b0;
    hi_sda = 1'b1; hi_sda_first = 1'b1; tick_cnt = 0;
  endtask

  task automatic issue(input logic [5:0] v);
    @(negedge clk);
    {c_ackchk, c_ack, c_rcv, c_stop, c_rstart, c_start} = v;
    @(negedge clk);
    {c_ackchk, c_ack, c_rcv, c_stop, c_rstart, c_start} = 6'd0;
  endtask

  task automatic wait_done(input string req, input int ticks);
    while (!done) @(negedge clk);
    check(active_cmd == 6'd0, "R8", active_cmd, 0);
    check(tick_cnt == ticks, req, tick_cnt, ticks);
    @(negedge clk);
    check(!done, "R9", done, 0);
  endtask

  task automatic t_reset();
    check(!sda_oe && !scl_oe, "R1 lines", {sda_oe, scl_oe}, 0);
    check(active_cmd == 0 && !done, "R1 status", {active_cmd, done}, 0);
    check(ack_stat == 0 && rx_data == 0, "R1 data", {ack_stat, rx_data}, 0);
  endtask

  task automatic t_start();
    clear_ev();
    issue(6'b000001);
    check(active_cmd == 6'b000001, "R8 start bit", active_cmd, 1);
    wait_done("R12 start ticks", 4);
    check(start_ev, "R2 start edge", start_ev, 1);
    check(sda_oe && scl_oe, "R2 end low", {sda_oe, scl_oe}, 3);
  endtask

  task automatic t_ackchk(input logic lvl);
    clear_ev();
    slave_byte = lvl ? 8'hFF : 8'h00; slave_idx = 0; slave_en = 1'b1;
    issue(6'b100000);
    wait_done("R12 ackchk ticks", 4);
    slave_en = 1'b0;
    check(ack_stat == lvl, "R7 ack_stat", ack_stat, lvl);
  endtask

  task automatic t_rcv(input logic [7:0] b);
    clear_ev();
    slave_byte = b; slave_idx = 0; slave_en = 1'b1;
    issue(6'b001000);
    check(active_cmd == 6'b001000, "R8 rcv bit", active_cmd, 8);
    wait_done("R12 rcv ticks", 32);
    slave_en = 1'b0;
    check(rx_data == b, "R5 rx_data", rx_data, b);
  endtask

  task automatic t_ack(input logic a);
    clear_ev();
    ack_data = a;
    issue(6'b010000);
    ack_data = ~a;
    wait_done("R12 ack ticks", 4);
    check(hi_sda == a, "R6 ack level", hi_sda, a);
  endtask

  task automatic t_rstart();
    clear_ev();
    issue(6'b000010);
    wait_done("R12 rstart ticks", 4);
    check(hi_sda_first == 1'b1, "R3 sda free at scl rise", hi_sda_first, 1);
    check(start_ev, "R3 start edge", start_ev, 1);
    check(sda_oe && scl_oe, "R3 end low", {sda_oe, scl_oe}, 3);
  endtask

  task automatic t_ignore();
    clear_ev();
    slave_byte = 8'h5A; slave_idx = 0; slave_en = 1'b1;
    issue(6'b001000);
    repeat (6) @(negedge clk);
    issue(6'b000100);
    check(active_cmd == 6'b001000, "R10 active kept", active_cmd, 8);
    wait_done("R12 rcv ticks", 32);
    slave_en = 1'b0;
    check(!stop_ev && scl_oe, "R10 no stop", {stop_ev, scl_oe}, 1);
    check(rx_data == 8'h5A, "R10 rx intact", rx_data, 8'h5A);
  endtask

  task automatic t_stop();
    clear_ev();
    issue(6'b000100);
    wait_done("R12 stop ticks", 4);
    check(stop_ev, "R4 stop edge", stop_ev, 1);
    check(!sda_oe && !scl_oe, "R4 released", {sda_oe, scl_oe}, 0);
  endtask

  task automatic t_prio();
    clear_ev();
    issue(6'b000101);
    check(active_cmd == 6'b000001, "R11 priority", active_cmd, 1);
    wait_done("R12 start ticks", 4);
    check(start_ev && !stop_ev, "R11 only start", {start_ev, stop_ev}, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_start();
    t_ackchk(1'b0);
    t_ackchk(1'b1);
    t_rcv(8'hA5);
    t_ack(1'b0);
    t_rcv(8'h3C);
    t_ack(1'b1);
    t_rstart();
    t_ignore();
    t_stop();
    t_prio();
    t_stop();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule